// File: doc/BRIEF.md
# Page Write Commit Engine

This block sits behind the serial bus slave of a small nonvolatile memory. It gathers the data bytes of one write command in a 32-entry page latch and then copies them into a 4096 x 8 storage array during a timed programming cycle. The slave opens a command with a start address and passes each received data byte with a one-cycle strobe. It ends the command with a one-cycle Stop pulse. While the programming cycle runs, the block drives `busy`, and the slave withholds its acknowledges for that time.

Bytes land in latch slots chosen by the low five bits of the running pointer. A long burst therefore wraps inside its 32-byte page, and any bytes beyond 32 overwrite the oldest ones. A 32-bit received-mask keeps slots that were never written from reaching the array. The protect input is read only in the Stop cycle. The programming time is a parameter counted in clock cycles. A registered read port serves the slave's read commands.

Top module: `page_commit_engine`

## Requirements
- R1: After a synchronous reset, `busy` is 0 and `ptr` is 0.
- R2: Each accepted data byte goes to page latch slot `ptr[4:0]`. The low five bits of `ptr` then advance modulo 32, and bits 11..5 stay unchanged, so a burst that passes the page end continues at the page start.
- R3: When more than 32 bytes arrive in one command, byte k+32 replaces byte k in the array image.
- R4: A Stop that follows at least one accepted byte, with `wp_in` low, raises `busy` on the next clock. `busy` then stays high for exactly max(PROG_CYCLES, 32) cycles, and the array holds the new bytes once it falls.
- R5: Only latch slots that received a byte in the current command are written. The other bytes of the page keep their previous contents.
- R6: A Stop with no accepted data byte writes nothing, and `busy` stays low.
- R7: If `wp_in` is high in the Stop cycle, nothing is written and `busy` stays low. A new command is accepted on the very next cycle.
- R8: Changes of `wp_in` after an accepted Stop have no effect on the programming cycle already started.
- R9: While `busy` is high, `cmd_start`, `wr_valid` and `stop_pulse` are ignored, and `ptr` holds its value.
- R10: A new command (`cmd_start`) discards bytes latched by an earlier command that ended without a Stop.
- R11: After programming, `ptr` addresses the location after the last byte written, wrapped within the page.
- R12: `rd_data` shows the array byte at `rd_addr` one clock after `rd_addr` is presented.
- R13: If inputs coincide in one cycle, `cmd_start` takes precedence over `stop_pulse`, and `stop_pulse` takes precedence over `wr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle pulse opening a write command |
| cmd_addr | input | 12 | Start address loaded with `cmd_start` |
| wr_valid | input | 1 | One-cycle strobe for a received data byte |
| wr_data | input | 8 | Data byte qualified by `wr_valid` |
| stop_pulse | input | 1 | One-cycle pulse marking the bus Stop |
| wp_in | input | 1 | Write-protect level, read in the Stop cycle |
| rd_addr | input | 12 | Array read address |
| rd_data | output | 8 | Registered array read data |
| busy | output | 1 | High during the programming cycle |
| ptr | output | 12 | Current address pointer |

## Verification
The main write path is driven with four patterns. A full aligned 32-byte page checks slot placement and the length of the busy window. A short burst starting two bytes before a page end shows wrap to the page start rather than carry into the next page. A 34-byte burst separates FIFO overwrite from a simple drop of late bytes. Single-byte writes into a prefilled page show that unreceived slots leave old contents in place. Protect, empty-Stop, abandoned-command and busy-time stimulus are each followed by a read-back of a known prefilled location and of `ptr`, so any write that should not have happened is seen at the ports.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_PROG = 1'b1
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcm_page_latch.sv
module pcm_page_latch #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_byte,
  output logic              rd_hit,
  output logic              any_valid
);

  logic [DATA_W-1:0]     slots [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] got_mask;

  // Data storage, no reset: validity lives in got_mask
  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_ofs] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  got_mask <= '0;
    else if (wr_en)  got_mask[wr_ofs] <= 1'b1;
  end

  assign rd_byte   = slots[rd_ofs];
  assign rd_hit    = got_mask[rd_ofs];
  assign any_valid = |got_mask;

endmodule

// File: rtl/pcm_prog_seq.sv
module pcm_prog_seq
  import pcm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int OFS_W      = $clog2(PAGE_BYTES),
  parameter int HOLD       = 64,
  parameter int CNT_W      = $clog2(HOLD + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic [ADDR_W-OFS_W-1:0] page_base,
  input  logic                    slot_hit,
  input  logic [DATA_W-1:0]       slot_data,
  output logic [OFS_W-1:0]        slot_ofs,
  output logic                    busy,
  output logic                    done,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_waddr,
  output logic [DATA_W-1:0]       mem_wdata
);

  seq_state_e              state;
  logic [CNT_W-1:0]        cnt;
  logic [ADDR_W-OFS_W-1:0] base_q;
  logic                    in_page;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEQ_IDLE;
      busy   <= 1'b0;
      cnt    <= '0;
      base_q <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (go) begin
          state  <= SEQ_PROG;
          busy   <= 1'b1;
          cnt    <= '0;
          base_q <= page_base;
        end
        SEQ_PROG: if (done) begin
          state <= SEQ_IDLE;
          busy  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign done      = (state == SEQ_PROG) && (cnt == CNT_W'(HOLD - 1));
  assign in_page   = cnt < CNT_W'(PAGE_BYTES);
  assign slot_ofs  = cnt[OFS_W-1:0];
  assign mem_we    = (state == SEQ_PROG) && in_page && slot_hit;
  assign mem_waddr = {base_q, cnt[OFS_W-1:0]};
  assign mem_wdata = slot_data;

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

endmodule

// File: rtl/pcm_array.sv
module pcm_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
  import pcm_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 400000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stop_pulse,
  input  logic              wp_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr
);

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int HOLD  = max_of(PROG_CYCLES, PAGE_BYTES);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic                    cmd_acc, stop_acc, byte_acc, go, clr;
  logic                    seq_done, any_valid, slot_hit, mem_we;
  logic [OFS_W-1:0]        slot_ofs;
  logic [DATA_W-1:0]       slot_data, mem_wdata;
  logic [ADDR_W-1:0]       mem_waddr;

  // Precedence: command > stop > data; nothing while busy
  assign cmd_acc  = cmd_start && !busy;
  assign stop_acc = stop_pulse && !busy && !cmd_start;
  assign byte_acc = wr_valid && !busy && !cmd_start && !stop_pulse;
  assign go       = stop_acc && any_valid && !wp_in;
  assign clr      = cmd_acc || seq_done || (stop_acc && !go);

  always_ff @(posedge clk) begin
    if (rst)           ptr <= '0;
    else if (cmd_acc)  ptr <= cmd_addr;
    else if (byte_acc) ptr <= {ptr[ADDR_W-1:OFS_W], ptr[OFS_W-1:0] + 1'b1};
  end

  pcm_page_latch #(
    .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)
  ) u_latch (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(byte_acc), .wr_ofs(ptr[OFS_W-1:0]), .wr_data(wr_data),
    .rd_ofs(slot_ofs), .rd_byte(slot_data), .rd_hit(slot_hit),
    .any_valid(any_valid)
  );

  pcm_prog_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
    .OFS_W(OFS_W), .HOLD(HOLD), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .go(go),
    .page_base(ptr[ADDR_W-1:OFS_W]),
    .slot_hit(slot_hit), .slot_data(slot_data), .slot_ofs(slot_ofs),
    .busy(busy), .done(seq_done),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  pcm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_pulse && !wp_in));

  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_pulse && wp_in && !busy) |=> !busy);

  // R9
  ptr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr));

  // R2
  page_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !cmd_start && !busy) |=>
      (ptr[ADDR_W-1:OFS_W] == $past(ptr[ADDR_W-1:OFS_W])));

endmodule

// File: tb/page_commit_engine_tb.sv
module page_commit_engine_tb;

  localparam int PROG = 40;
  localparam int HOLD = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [11:0] cmd_addr = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        stop_pulse = 1'b0;
  logic        wp_in = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;
  logic [11:0] ptr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  page_commit_engine #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .stop_pulse(stop_pulse),
    .wp_in(wp_in), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .ptr(ptr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [11:0] a);
    @(negedge clk); cmd_start = 1'b1; cmd_addr = a;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // Stop and count busy cycles; returns count
  task automatic send_stop(input logic wp, output int n);
    @(negedge clk); stop_pulse = 1'b1; wp_in = wp;
    @(negedge clk); stop_pulse = 1'b0; wp_in = 1'b0;
    n = 0;
    while (busy && n < HOLD + 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [7:0] e);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(req, int'(rd_data), int'(e));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 ptr after reset", int'(ptr), 0);
  endtask

  task automatic t_full_page();
    int n;
    send_cmd(12'h040);
    for (int i = 0; i < 32; i++) send_byte(8'(8'hA0 + i));
    send_stop(1'b0, n);
    chk("R4 busy length", n, HOLD);
    chk("R11 ptr after full page", int'(ptr), 12'h040);
    for (int i = 0; i < 32; i++) rd_chk("R4 R12 page data", 12'(12'h040 + i), 8'(8'hA0 + i));
  endtask

  task automatic t_wrap();
    int n;
    send_cmd(12'h05E);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
    chk("R2 ptr wrapped before stop", int'(ptr), 12'h042);
    send_stop(1'b0, n);
    rd_chk("R2 byte at 05E", 12'h05E, 8'h01);
    rd_chk("R2 byte at 05F", 12'h05F, 8'h02);
    rd_chk("R2 wrap to 040", 12'h040, 8'h03);
    rd_chk("R2 wrap to 041", 12'h041, 8'h04);
    rd_chk("R5 untouched 042", 12'h042, 8'hA2);
    chk("R11 ptr after wrap", int'(ptr), 12'h042);
  endtask

  task automatic t_overflow();
    int n;
    send_cmd(12'h0A0);
    for (int k = 0; k < 34; k++) send_byte(8'(8'h10 + k));
    send_stop(1'b0, n);
    rd_chk("R3 slot0 replaced", 12'h0A0, 8'h30);
    rd_chk("R3 slot1 replaced", 12'h0A1, 8'h31);
    rd_chk("R3 slot2 kept", 12'h0A2, 8'h12);
    rd_chk("R3 slot31 kept", 12'h0BF, 8'h2F);
    chk("R11 ptr after overflow", int'(ptr), 12'h0A2);
  endtask

  task automatic t_empty_stop();
    int n;
    send_cmd(12'h123);
    send_stop(1'b0, n);
    chk("R6 no busy on empty stop", n, 0);
    chk("R6 ptr after empty stop", int'(ptr), 12'h123);
  endtask

  task automatic t_protect();
    int n;
    send_cmd(12'h043);
    send_byte(8'h99);
    send_stop(1'b1, n);
    chk("R7 no busy when protected", n, 0);
    rd_chk("R7 protected byte unchanged", 12'h043, 8'hA3);
    send_cmd(12'h043);
    send_byte(8'h77);
    send_stop(1'b0, n);
    chk("R7 next command accepted", n, HOLD);
    rd_chk("R7 follow-up write landed", 12'h043, 8'h77);
  endtask

  task automatic t_busy_ignore();
    send_cmd(12'h044);
    send_byte(8'h55);
    @(negedge clk); stop_pulse = 1'b1;
    @(negedge clk); stop_pulse = 1'b0;
    chk("R4 busy after stop", int'(busy), 1);
    wp_in = 1'b1;          // R8: protect raised mid-cycle
    send_cmd(12'h045);     // R9: ignored while busy
    send_byte(8'hEE);
    @(negedge clk); stop_pulse = 1'b1;
    @(negedge clk); stop_pulse = 1'b0;
    chk("R9 ptr held while busy", int'(ptr), 12'h045);
    while (busy) @(negedge clk);
    wp_in = 1'b0;
    rd_chk("R8 write done despite protect", 12'h044, 8'h55);
    rd_chk("R9 busy-time data dropped", 12'h045, 8'hA5);
    chk("R11 ptr after single byte", int'(ptr), 12'h045);
  endtask

  task automatic t_abandon();
    int n;
    send_cmd(12'h048);
    send_byte(8'h11);
    send_cmd(12'h050);
    send_byte(8'h22);
    send_stop(1'b0, n);
    rd_chk("R10 abandoned byte not written", 12'h048, 8'hA8);
    rd_chk("R10 new command written", 12'h050, 8'h22);
    chk("R10 ptr", int'(ptr), 12'h051);
  endtask

  task automatic t_precedence();
    int n;
    // R13: cmd_start with wr_valid in one cycle, the byte is dropped
    @(negedge clk); cmd_start = 1'b1; cmd_addr = 12'h060; wr_valid = 1'b1; wr_data = 8'h5A;
    @(negedge clk); cmd_start = 1'b0; wr_valid = 1'b0;
    chk("R13 cmd wins over data", int'(ptr), 12'h060);
    send_stop(1'b0, n);
    chk("R13 no data so no busy", n, 0);
  endtask

  initial begin
    t_reset();
    t_full_page();
    t_wrap();
    t_overflow();
    t_empty_stop();
    t_protect();
    t_busy_ignore();
    t_abandon();
    t_precedence();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule